// File: doc/BRIEF.md
# Host Controller Interrupt and Command Status Registers

This block holds the interrupt and command status registers of a USB host controller. Internal logic reports events on a vector of one-cycle pulses. Each pulse sets a sticky status bit, and the host clears these bits by writing ones to them. An enable word carries one bit per event and a master bit, and together they gate the status bits onto a single interrupt line. The block also keeps a 2-bit scheduling overrun counter, the current functional state of the controller, and a software reset request bit that clears itself.

The host reaches the registers through a synchronous command port. The low seven bits of the command code pick a register, and bit 7 marks a write. Reads are combinational from the code presented, and writes take effect on the clock edge where the strobe is seen. The host starts a software reset by writing 1 to bit 0 of the command status register. The block then reports busy for a fixed number of cycles and refuses all accesses during that time. When the reset finishes, the block clears its operational registers and leaves the controller in the suspend state.

Top module: `hc_irq_status_regs`

## Requirements
- R1: After the reset pin is released, every register reads 0, `irq` is 0, `busy` is 0 and `funcState` is 00 (reset state).
- R2: The interrupt status register (read code 03h, write code 83h) holds one bit per event at positions [NUM_EVENTS-1:0]. A write clears each bit that has a 1 in the written data, a 0 in the data leaves the bit unchanged, and a write never sets a bit.
- R3: `irq` is 1 exactly when the master enable (bit 31 of the enable register, codes 04h/84h) is 1 and at least one status bit is 1 while its matching enable bit at the same position is 1.
- R4: The overrun count sits at bits 17:16 of the command status register (codes 02h/82h). It increments on each pulse of event 0 and wraps from 11b to 00b. It keeps counting while status bit 0 is already set.
- R5: If an event pulse arrives in the same cycle as a host write that clears that bit, the bit ends up set. Other bits cleared by the same write are cleared.
- R6: Bit 7 of the command code selects a write and bits 6:0 select the register. A code that selects no register reads as 0 and has no effect when written. Reserved bits read as 0, so writing all ones to the enable register reads back as 8000007Fh with the default 7 events.
- R7: Writing 82h with data bit 0 set starts a software reset. `busy` rises after that clock edge and stays high for exactly RST_CYCLES cycles.
- R8: While `busy` is high, reads return 0 and writes to any register are ignored.
- R9: When the reset finishes, the status register, the enable register and the overrun count are all 0. `funcState` reads 11 (suspend) at bits 7:6 of the control register (codes 01h/81h), and the reset bit reads 0.
- R10: In the command status register, writing 0 to bit 0 starts no reset, and writing bits 17:16 does not change the count.
- R11: Outside a reset, a write to code 81h loads `funcState` from bits 7:6 of the data (00 reset, 01 resume, 10 operational, 11 suspend).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdStrobe | input | 1 | Write access strobe for the presented command |
| cmdCode | input | 8 | Command code: bit 7 write, bits 6:0 register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the register selected by cmdCode |
| busy | output | 1 | Software reset in progress, accesses refused |
| eventIn | input | NUM_EVENTS | One-cycle event pulses; bit 0 is scheduling overrun |
| irq | output | 1 | Interrupt request |
| funcState | output | 2 | Controller functional state |

## Verification
On every cycle, the assertions check that status bits rise only after an event pulse, that a pulse always leaves its bit set, that the overrun count steps by one modulo four on each overrun pulse, and that reset completion clears the count and enables and drops `busy` after the full window. Several behaviours show only in the directed scenarios. These are the exact length of the busy window, the read-back of each register through the command codes, the refusal of accesses during reset, and the suspend state left behind once the reset finishes.

// File: rtl/hcis_pkg.sv
package hcis_pkg;

  typedef enum logic [1:0] {
    FS_RESET   = 2'b00,
    FS_RESUME  = 2'b01,
    FS_OPER    = 2'b10,
    FS_SUSPEND = 2'b11
  } funcState_e;

  localparam logic [6:0] REG_CONTROL = 7'h01;
  localparam logic [6:0] REG_CMDSTAT = 7'h02;
  localparam logic [6:0] REG_INTSTAT = 7'h03;
  localparam logic [6:0] REG_INTEN   = 7'h04;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CONTROL,
    SEL_CMDSTAT,
    SEL_INTSTAT,
    SEL_INTEN
  } readSel_e;

  typedef struct packed {
    logic     wrControl;
    logic     wrIntStat;
    logic     wrIntEn;
    logic     rstStart;
    logic     rstDone;
    logic     rstActive;
    readSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/hcis_ctrl.sv
module hcis_ctrl
  import hcis_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdStrobe,
  input  logic [7:0]  cmdCode,
  input  logic        rstReqBit,
  output ctrlStrobe_t strb,
  output logic        busy
);

  localparam int CW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(RST_CYCLES - 1);

  logic          rstActive;
  logic [CW-1:0] rstCnt;
  logic          isWrite;
  logic [6:0]    regId;
  logic          accept;
  logic          rstDone;

  assign isWrite = cmdCode[7];
  assign regId   = cmdCode[6:0];
  assign accept  = cmdStrobe && !rstActive && isWrite;
  assign rstDone = rstActive && (rstCnt == LAST_CNT);

  always_comb begin
    strb           = '0;
    strb.wrControl = accept && (regId == REG_CONTROL);
    strb.wrIntStat = accept && (regId == REG_INTSTAT);
    strb.wrIntEn   = accept && (regId == REG_INTEN);
    strb.rstStart  = accept && (regId == REG_CMDSTAT) && rstReqBit;
    strb.rstDone   = rstDone;
    strb.rstActive = rstActive;
    if (rstActive) begin
      strb.rdSel = SEL_NONE;
    end else begin
      unique case (regId)
        REG_CONTROL: strb.rdSel = SEL_CONTROL;
        REG_CMDSTAT: strb.rdSel = SEL_CMDSTAT;
        REG_INTSTAT: strb.rdSel = SEL_INTSTAT;
        REG_INTEN:   strb.rdSel = SEL_INTEN;
        default:     strb.rdSel = SEL_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstActive <= 1'b0;
      rstCnt    <= '0;
    end else if (strb.rstStart) begin
      rstActive <= 1'b1;
      rstCnt    <= '0;
    end else if (rstDone) begin
      rstActive <= 1'b0;
      rstCnt    <= '0;
    end else if (rstActive) begin
      rstCnt <= rstCnt + 1'b1;
    end
  end

  assign busy = rstActive;

  // R7
  busy_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstDone |=> !busy);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !rstDone) |=> busy);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rstStart |=> busy);

endmodule

// File: rtl/hcis_datapath.sv
module hcis_datapath
  import hcis_pkg::*;
#(
  parameter int NUM_EVENTS = 7,
  parameter int OVR_EVENT  = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strb,
  input  logic [NUM_EVENTS-1:0] wrEvt,
  input  logic                  wrMaster,
  input  logic [1:0]            wrState,
  input  logic [NUM_EVENTS-1:0] eventIn,
  output logic [31:0]           rdData,
  output logic                  irq,
  output logic [1:0]            funcState
);

  logic [NUM_EVENTS-1:0] intStatus;
  logic [NUM_EVENTS-1:0] intEnable;
  logic                  masterEn;
  logic [1:0]            ovrCount;
  funcState_e            stateQ;

  // one sticky cell per event: set beats host clear
  for (genvar i = 0; i < NUM_EVENTS; i++) begin : g_statusCell
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        intStatus[i] <= 1'b0;
      end else if (strb.rstDone) begin
        intStatus[i] <= 1'b0;
      end else if (eventIn[i]) begin
        intStatus[i] <= 1'b1;
      end else if (strb.wrIntStat && wrEvt[i]) begin
        intStatus[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovrCount <= 2'b00;
    end else if (strb.rstDone) begin
      ovrCount <= 2'b00;
    end else if (eventIn[OVR_EVENT]) begin
      ovrCount <= ovrCount + 2'b01;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEnable <= '0;
      masterEn  <= 1'b0;
    end else if (strb.rstDone) begin
      intEnable <= '0;
      masterEn  <= 1'b0;
    end else if (strb.wrIntEn) begin
      intEnable <= wrEvt;
      masterEn  <= wrMaster;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= FS_RESET;
    end else if (strb.rstStart) begin
      stateQ <= FS_SUSPEND;
    end else if (strb.wrControl) begin
      stateQ <= funcState_e'(wrState);
    end
  end

  assign funcState = stateQ;
  assign irq       = masterEn && |(intStatus & intEnable);

  always_comb begin
    rdData = '0;
    unique case (strb.rdSel)
      SEL_CONTROL: rdData[7:6] = stateQ;
      SEL_CMDSTAT: begin
        rdData[17:16] = ovrCount;
        rdData[0]     = strb.rstActive;
      end
      SEL_INTSTAT: rdData[NUM_EVENTS-1:0] = intStatus;
      SEL_INTEN: begin
        rdData[NUM_EVENTS-1:0] = intEnable;
        rdData[31]             = masterEn;
      end
      default: rdData = '0;
    endcase
  end

  // R2
  status_set_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intStatus & ~$past(intStatus) & ~$past(eventIn)) == '0);

  // R5
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rstDone |=> ((intStatus & $past(eventIn)) == $past(eventIn)));

  // R4
  ovr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eventIn[OVR_EVENT] && !strb.rstDone) |=> (ovrCount == $past(ovrCount) + 2'b01));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rstDone |=> (ovrCount == 2'b00 && intEnable == '0 && !masterEn));

endmodule

// File: rtl/hc_irq_status_regs.sv
module hc_irq_status_regs
  import hcis_pkg::*;
#(
  parameter int NUM_EVENTS = 7,
  parameter int OVR_EVENT  = 0,
  parameter int RST_CYCLES = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdStrobe,
  input  logic [7:0]            cmdCode,
  input  logic [31:0]           wrData,
  output logic [31:0]           rdData,
  output logic                  busy,
  input  logic [NUM_EVENTS-1:0] eventIn,
  output logic                  irq,
  output logic [1:0]            funcState
);

  ctrlStrobe_t strb;

  hcis_ctrl #(
    .RST_CYCLES(RST_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdStrobe(cmdStrobe),
    .cmdCode  (cmdCode),
    .rstReqBit(wrData[0]),
    .strb     (strb),
    .busy     (busy)
  );

  hcis_datapath #(
    .NUM_EVENTS(NUM_EVENTS),
    .OVR_EVENT (OVR_EVENT)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrEvt    (wrData[NUM_EVENTS-1:0]),
    .wrMaster (wrData[31]),
    .wrState  (wrData[7:6]),
    .eventIn  (eventIn),
    .rdData   (rdData),
    .irq      (irq),
    .funcState(funcState)
  );

endmodule

// File: tb/hc_irq_status_regs_bench.sv
module hc_irq_status_regs_bench;

  localparam int NEV = 7;
  localparam int RSTC = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdStrobe = 1'b0;
  logic [7:0]  cmdCode = 8'h00;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        busy;
  logic [NEV-1:0] eventIn = '0;
  logic        irq;
  logic [1:0]  funcState;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  hc_irq_status_regs #(.NUM_EVENTS(NEV), .OVR_EVENT(0), .RST_CYCLES(RSTC)) u_hc_irq_status_regs (
    .clk(clk), .rstN(rstN), .cmdStrobe(cmdStrobe), .cmdCode(cmdCode),
    .wrData(wrData), .rdData(rdData), .busy(busy), .eventIn(eventIn),
    .irq(irq), .funcState(funcState)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic write(input logic [7:0] code, input logic [31:0] data);
    @(negedge clk);
    cmdStrobe = 1'b1; cmdCode = code; wrData = data;
    @(negedge clk);
    cmdStrobe = 1'b0; wrData = '0;
  endtask

  task automatic readReg(input logic [7:0] code, output logic [31:0] val);
    cmdCode = code;
    #1;
    val = rdData;
  endtask

  task automatic pulse(input logic [NEV-1:0] v);
    @(negedge clk);
    eventIn = v;
    @(negedge clk);
    eventIn = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int c = 1; c <= 4; c++) begin
      readReg(8'(c), v);
      check("R1 register zero", v, 32'h0);
    end
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 busy", {31'b0, busy}, 0);
    check("R1 funcState", {30'b0, funcState}, 0);
  endtask

  task automatic t_decode();
    logic [31:0] v;
    write(8'h84, 32'hFFFF_FFFF);
    readReg(8'h04, v);
    check("R6 reserved bits of enable", v, 32'h8000_007F);
    write(8'h85, 32'hFFFF_FFFF);
    readReg(8'h05, v);
    check("R6 unknown code reads 0", v, 32'h0);
    readReg(8'h03, v);
    check("R6 unknown write no effect", v, 32'h0);
    write(8'h84, 32'h0);
    readReg(8'h04, v);
    check("R6 enable cleared", v, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    pulse(7'b0101010);
    readReg(8'h03, v);
    check("R2 events set", v, 32'h2A);
    write(8'h83, 32'h0000_0003);
    readReg(8'h03, v);
    check("R2 clear one, never set", v, 32'h28);
    write(8'h83, 32'h0);
    readReg(8'h03, v);
    check("R2 zero leaves bits", v, 32'h28);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    write(8'h84, 32'h0000_0008);
    #1 check("R3 no master", {31'b0, irq}, 0);
    write(8'h84, 32'h8000_0008);
    #1 check("R3 master and match", {31'b0, irq}, 1);
    write(8'h84, 32'h8000_0004);
    #1 check("R3 enabled bit not set", {31'b0, irq}, 0);
    write(8'h84, 32'h8000_0020);
    write(8'h83, 32'h7F);
    #1 check("R3 cleared status", {31'b0, irq}, 0);
    readReg(8'h03, v);
    check("R2 all cleared", v, 32'h0);
    write(8'h84, 32'h0);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    logic [1:0] expCnt;
    expCnt = 2'b00;
    for (int k = 0; k < 5; k++) begin
      pulse(7'b0000001);
      expCnt = expCnt + 2'b01;
      readReg(8'h02, v);
      check("R4 overrun count", {30'b0, v[17:16]}, {30'b0, expCnt});
      readReg(8'h03, v);
      check("R4 status bit 0 stays set", v, 32'h1);
    end
    write(8'h82, 32'h0003_0000);
    #1 check("R10 no reset on bit0=0", {31'b0, busy}, 0);
    readReg(8'h02, v);
    check("R10 count read-only", v, 32'h0001_0000);
    write(8'h83, 32'h1);
  endtask

  task automatic t_setwins();
    logic [31:0] v;
    pulse(7'b0000110);
    @(negedge clk);
    eventIn = 7'b0000010; cmdStrobe = 1'b1; cmdCode = 8'h83; wrData = 32'h6;
    @(negedge clk);
    eventIn = '0; cmdStrobe = 1'b0; wrData = '0;
    readReg(8'h03, v);
    check("R5 set wins over clear", v, 32'h2);
    write(8'h83, 32'h7F);
  endtask

  task automatic t_state();
    logic [31:0] v;
    write(8'h81, 32'h0000_0080);
    readReg(8'h01, v);
    check("R11 control state write", v, 32'h80);
    check("R11 funcState port", {30'b0, funcState}, 32'h2);
  endtask

  task automatic t_swreset();
    logic [31:0] v;
    int n;
    write(8'h84, 32'h8000_0011);
    pulse(7'b0010001);
    write(8'h82, 32'h1);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    check("R7 busy length", n, RSTC);
    readReg(8'h03, v);
    check("R9 status cleared", v, 32'h0);
    readReg(8'h04, v);
    check("R9 enable cleared", v, 32'h0);
    readReg(8'h02, v);
    check("R9 count and reset bit cleared", v, 32'h0);
    readReg(8'h01, v);
    check("R9 suspend state", v, 32'hC0);
    // second reset: accesses during busy are refused
    write(8'h81, 32'h0000_0080);
    write(8'h82, 32'h1);
    readReg(8'h01, v);
    check("R8 read during busy", v, 32'h0);
    write(8'h81, 32'h0000_0040);
    write(8'h84, 32'hFFFF_FFFF);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    check("R8 ignored state write", {30'b0, funcState}, 32'h3);
    readReg(8'h04, v);
    check("R8 ignored enable write", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_w1c();
    t_irq();
    t_overrun();
    t_setwins();
    t_state();
    t_swreset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule